// File: doc/BRIEF.md
# Register-Map Access Strobe Decoder

This block turns a qualified register-interface request into one-hot access strobes for a fixed register map. The map is made of plain registers the width of one access word, one wide register that spans several access words, and a two-dimensional register array. Each request carries a valid qualifier and a byte address. The address is an offset into the map, so every register's absolute location has the map base subtracted from it before comparison. When an address matches a register, the strobe for that register (or for that subword of the wide register, or for that array element) goes high.

The wide register gets one strobe per access-width subword. Each field of the wide register also gets its own strobe. That strobe is the OR of only the subword strobes that the field's bit range overlaps, so a field that crosses a word boundary responds to either word. When a valid request matches nothing, the block raises a miss flag instead. All results are registered and appear one clock after the request. A synchronous active-high reset clears them.

Top module: `regmap_decoder`

## Requirements
- R1: With `req_valid` high, `plain_strb[k]` is 1 exactly when `req_addr` equals plain register k's absolute address minus the map base. With the defaults these offsets are 0x00 and 0x04.
- R2: Addresses are compared as offsets from the map base (default 0x1000), not as absolute addresses. A request to an absolute address such as 0x1000 or 0x1008 matches nothing.
- R3: The wide register (default 64 bits at offset 0x08, with a 32-bit access width) has WIDE_W/ACC_W subword strobes. Subword i decodes at the register offset plus i*ACC_W/8 bytes, so the defaults give 0x08 and 0x0C.
- R4: A field whose bits all sit inside one subword has a strobe equal to that subword's strobe. With the defaults, field 0 (bits 7:0) follows subword 0 and field 2 (bits 47:40) follows subword 1.
- R5: A field whose bits span several subwords has a strobe equal to the OR of the subwords from lsb/ACC_W through msb/ACC_W. With the defaults, field 1 (bits 39:24) is high for either subword.
- R6: Array element [i][j] strobes on `arr_strb[i*D1+j]` at array offset + i*(ELEM_STRIDE*D1) + j*ELEM_STRIDE. The inner stride is the element stride and the outer stride is the inner stride times the inner size. The defaults give a 2x3 array at offset 0x20 with an element stride of 4, which places the elements at 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34.
- R7: With `req_valid` low, every strobe and `miss` are 0 on the following cycle, whatever the address.
- R8: With `req_valid` high and an address that matches no register (unmapped, absolute or misaligned), every strobe is 0 and `miss` is 1.
- R9: At most one of the register-level strobes (plain, wide subword, array element) is high in any cycle.
- R10: While `rst` is high at a clock edge, all outputs are 0 after that edge.
- R11: Every output reflects the request that was sampled at the previous rising edge of `clk`, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Qualified request valid |
| req_addr | input | ADDR_W | Byte offset into the map |
| plain_strb | output | N_PLAIN | Plain register strobes |
| wide_strb | output | WIDE_W/ACC_W | Wide register subword strobes |
| field_strb | output | N_FIELD | Wide register field strobes |
| arr_strb | output | ARR_D0*ARR_D1 | Array element strobes, index i*D1+j |
| miss | output | 1 | Valid request matched no register |

## Verification
Every result is due exactly one rising edge after the request that caused it. The driver places a request on the falling edge and pushes the expected strobe set into a queue at the same time. The monitor pops the queue a short delay after the next rising edge, so each comparison lands on the cycle in which that request's registered result is visible and before the next request can change it. Reset is checked separately, after an edge taken with reset high.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

  // Bit mask of the subwords that bit range [msb:lsb] overlaps.
  function automatic logic [31:0] span_mask(input int lsb, input int msb, input int acc_w);
    logic [31:0] m;
    m = '0;
    for (int w = lsb / acc_w; w <= msb / acc_w; w++) m[w] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/addr_match.sv
module addr_match #(
  parameter int          ADDR_W = 16,
  parameter int unsigned OFFSET = 0
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(OFFSET);

  assign hit = valid && (addr == OFF);
endmodule

// File: rtl/wide_decode.sv
module wide_decode #(
  parameter int          ADDR_W = 16,
  parameter int unsigned OFFSET = 8,
  parameter int          N_SUB  = 2,
  parameter int          STEP   = 4
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_SUB-1:0]  sub_hit
);
  for (genvar s = 0; s < N_SUB; s++) begin : g_sub
    addr_match #(.ADDR_W(ADDR_W), .OFFSET(OFFSET + s * STEP)) u_m (
      .valid(valid), .addr(addr), .hit(sub_hit[s])
    );
  end
endmodule

// File: rtl/array_decode.sv
module array_decode #(
  parameter int          ADDR_W      = 16,
  parameter int unsigned BASE        = 32,
  parameter int          D0          = 2,
  parameter int          D1          = 3,
  parameter int          ELEM_STRIDE = 4
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic [D0*D1-1:0]  elem_hit
);
  // inner stride is the element stride, outer is inner times inner size
  localparam int INNER = ELEM_STRIDE;
  localparam int OUTER = INNER * D1;

  for (genvar i = 0; i < D0; i++) begin : g_outer
    for (genvar j = 0; j < D1; j++) begin : g_inner
      addr_match #(.ADDR_W(ADDR_W), .OFFSET(BASE + i * OUTER + j * INNER)) u_m (
        .valid(valid), .addr(addr), .hit(elem_hit[i*D1+j])
      );
    end
  end
endmodule

// File: rtl/field_strobe.sv
module field_strobe
  import regmap_pkg::*;
#(
  parameter int N_SUB = 2,
  parameter int LSB   = 0,
  parameter int MSB   = 7,
  parameter int ACC_W = 32
) (
  input  logic [N_SUB-1:0] sub_hit,
  output logic             strb
);
  localparam logic [31:0]      FULL = span_mask(LSB, MSB, ACC_W);
  localparam logic [N_SUB-1:0] MASK = FULL[N_SUB-1:0];

  assign strb = |(sub_hit & MASK);
endmodule

// File: rtl/regmap_decoder.sv
module regmap_decoder #(
  parameter int          ADDR_W      = 16,
  parameter int          ACC_W       = 32,
  parameter int unsigned MAP_BASE    = 32'h1000,
  parameter int          N_PLAIN     = 2,
  parameter int unsigned PLAIN_ABS [N_PLAIN] = '{32'h1000, 32'h1004},
  parameter int unsigned WIDE_ABS    = 32'h1008,
  parameter int          WIDE_W      = 64,
  parameter int          N_FIELD     = 3,
  parameter int          FIELD_LSB [N_FIELD] = '{0, 24, 40},
  parameter int          FIELD_MSB [N_FIELD] = '{7, 39, 47},
  parameter int unsigned ARR_ABS     = 32'h1020,
  parameter int          ARR_D0      = 2,
  parameter int          ARR_D1      = 3,
  parameter int          ARR_STRIDE  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic [N_PLAIN-1:0]       plain_strb,
  output logic [WIDE_W/ACC_W-1:0]  wide_strb,
  output logic [N_FIELD-1:0]       field_strb,
  output logic [ARR_D0*ARR_D1-1:0] arr_strb,
  output logic                     miss
);
  localparam int N_SUB = WIDE_W / ACC_W;
  localparam int ACC_B = ACC_W / 8;
  localparam int N_ARR = ARR_D0 * ARR_D1;

  logic [N_PLAIN-1:0] plain_c;
  logic [N_SUB-1:0]   wide_c;
  logic [N_FIELD-1:0] field_c;
  logic [N_ARR-1:0]   arr_c;
  logic               miss_c;

  for (genvar k = 0; k < N_PLAIN; k++) begin : g_plain
    addr_match #(.ADDR_W(ADDR_W), .OFFSET(PLAIN_ABS[k] - MAP_BASE)) u_m (
      .valid(req_valid), .addr(req_addr), .hit(plain_c[k])
    );
  end

  wide_decode #(
    .ADDR_W(ADDR_W), .OFFSET(WIDE_ABS - MAP_BASE), .N_SUB(N_SUB), .STEP(ACC_B)
  ) u_wide (
    .valid(req_valid), .addr(req_addr), .sub_hit(wide_c)
  );

  for (genvar f = 0; f < N_FIELD; f++) begin : g_field
    field_strobe #(
      .N_SUB(N_SUB), .LSB(FIELD_LSB[f]), .MSB(FIELD_MSB[f]), .ACC_W(ACC_W)
    ) u_f (
      .sub_hit(wide_c), .strb(field_c[f])
    );
  end

  array_decode #(
    .ADDR_W(ADDR_W), .BASE(ARR_ABS - MAP_BASE), .D0(ARR_D0), .D1(ARR_D1),
    .ELEM_STRIDE(ARR_STRIDE)
  ) u_arr (
    .valid(req_valid), .addr(req_addr), .elem_hit(arr_c)
  );

  assign miss_c = req_valid && !(|{plain_c, wide_c, arr_c});

  always_ff @(posedge clk) begin
    if (rst) begin
      plain_strb <= '0;
      wide_strb  <= '0;
      field_strb <= '0;
      arr_strb   <= '0;
      miss       <= 1'b0;
    end else begin
      plain_strb <= plain_c;
      wide_strb  <= wide_c;
      field_strb <= field_c;
      arr_strb   <= arr_c;
      miss       <= miss_c;
    end
  end
endmodule

// File: rtl/regmap_decoder_chk.sv
module regmap_decoder_chk #(
  parameter int          ADDR_W     = 16,
  parameter int          ACC_W      = 32,
  parameter int          N_PLAIN    = 2,
  parameter int          N_SUB      = 2,
  parameter int          N_FIELD    = 3,
  parameter int          N_ARR      = 6,
  parameter int unsigned PLAIN0_OFF = 0,
  parameter int          FIELD_LSB [N_FIELD] = '{0, 24, 40},
  parameter int          FIELD_MSB [N_FIELD] = '{7, 39, 47}
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [N_PLAIN-1:0] plain_strb,
  input logic [N_SUB-1:0]   wide_strb,
  input logic [N_FIELD-1:0] field_strb,
  input logic [N_ARR-1:0]   arr_strb,
  input logic               miss
);
  // R1, R11: plain register 0 strobes one cycle after a matching request
  assert_plain_hit_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == ADDR_W'(PLAIN0_OFF)) |=> plain_strb[0]);

  // R7: no request, nothing asserted next cycle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!(|{plain_strb, wide_strb, field_strb, arr_strb}) && !miss));

  // R8: a miss never coincides with a strobe
  assert_miss_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    miss |-> !(|{plain_strb, wide_strb, field_strb, arr_strb}));

  // R9: register-level strobes are one-hot or idle
  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({plain_strb, wide_strb, arr_strb}));

  // R10: reset leaves every output low
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!(|{plain_strb, wide_strb, field_strb, arr_strb}) && !miss));

  for (genvar f = 0; f < N_FIELD; f++) begin : g_fchk
    localparam int LO = FIELD_LSB[f] / ACC_W;
    localparam int HI = FIELD_MSB[f] / ACC_W;
    if (LO == HI) begin : g_single
      // R4: a field inside one subword follows it
      assert_field_single_R4: assert property (@(posedge clk) disable iff (rst)
        field_strb[f] == wide_strb[LO]);
    end else begin : g_span
      // R5: a spanning field follows any of its subwords
      assert_field_span_R5: assert property (@(posedge clk) disable iff (rst)
        field_strb[f] == (|wide_strb[HI:LO]));
    end
  end
endmodule

bind regmap_decoder regmap_decoder_chk #(
  .ADDR_W(ADDR_W), .ACC_W(ACC_W), .N_PLAIN(N_PLAIN), .N_SUB(WIDE_W / ACC_W),
  .N_FIELD(N_FIELD), .N_ARR(ARR_D0 * ARR_D1), .PLAIN0_OFF(PLAIN_ABS[0] - MAP_BASE),
  .FIELD_LSB(FIELD_LSB), .FIELD_MSB(FIELD_MSB)
) u_chk (.*);

// File: tb/regmap_decoder_test.sv
`timescale 1ns/1ps
module regmap_decoder_test;
  typedef struct packed {
    logic [1:0] plain;
    logic [1:0] wide;
    logic [2:0] field;
    logic [5:0] arr;
    logic       miss;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  plain_strb;
  logic [1:0]  wide_strb;
  logic [2:0]  field_strb;
  logic [5:0]  arr_strb;
  logic        miss;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  regmap_decoder uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .plain_strb(plain_strb), .wide_strb(wide_strb), .field_strb(field_strb),
    .arr_strb(arr_strb), .miss(miss)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Expected outputs built from the requirements' address map
  function automatic exp_t model(input logic v, input logic [15:0] a);
    exp_t e;
    e = '0;
    if (v) begin
      e.plain[0] = (a == 16'h00);
      e.plain[1] = (a == 16'h04);
      e.wide[0]  = (a == 16'h08);
      e.wide[1]  = (a == 16'h0C);
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 3; j++)
          e.arr[i*3+j] = (a == 16'(32'h20 + i * 12 + j * 4));
      e.field[0] = e.wide[0];
      e.field[1] = e.wide[0] | e.wide[1];
      e.field[2] = e.wide[1];
      e.miss = !(|{e.plain, e.wide, e.arr});
    end
    return e;
  endfunction

  task automatic drive(input logic v, input logic [15:0] a, input string tag);
    @(negedge clk);
    req_valid = v;
    req_addr  = a;
    exp_q.push_back(model(v, a));
    tag_q.push_back(tag);
  endtask

  // Monitor: the result for a request is visible after the next rising edge (R11)
  always @(posedge clk) begin
    #2;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, "/R1"}, "plain_strb", int'(plain_strb), int'(e.plain));
      check({t, "/R3"}, "wide_strb",  int'(wide_strb),  int'(e.wide));
      check({t, "/R4"}, "field0",     int'(field_strb[0]), int'(e.field[0]));
      check({t, "/R5"}, "field1",     int'(field_strb[1]), int'(e.field[1]));
      check({t, "/R4"}, "field2",     int'(field_strb[2]), int'(e.field[2]));
      check({t, "/R6"}, "arr_strb",   int'(arr_strb),   int'(e.arr));
      check({t, "/R8"}, "miss",       int'(miss),       int'(e.miss));
      check({t, "/R9"}, "onehot", int'($countones({plain_strb, wide_strb, arr_strb}) <= 1), 1);
    end
  end

  initial begin
    // R10: outputs low after an edge with reset high
    repeat (3) @(posedge clk);
    #2;
    check("R10", "outputs in reset",
          int'({plain_strb, wide_strb, field_strb, arr_strb, miss}), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1, R3, R6, R11: sweep mapped and unmapped offsets
    for (int a = 0; a < 16'h40; a += 4) drive(1'b1, 16'(a), "R11 sweep");
    // R5: back to back on both halves of the wide register
    drive(1'b1, 16'h08, "R5 low half");
    drive(1'b1, 16'h0C, "R5 high half");
    // R2: absolute addresses must not decode
    drive(1'b1, 16'h1000, "R2 abs plain");
    drive(1'b1, 16'h1008, "R2 abs wide");
    drive(1'b1, 16'h1024, "R2 abs array");
    // R8: misaligned and far addresses
    drive(1'b1, 16'h09, "R8 misaligned");
    drive(1'b1, 16'h22, "R8 misaligned arr");
    drive(1'b1, 16'hFFFF, "R8 top");
    // R7: valid low on mapped addresses
    drive(1'b0, 16'h00, "R7 idle plain");
    drive(1'b0, 16'h0C, "R7 idle wide");
    drive(1'b0, 16'h34, "R7 idle arr");
    drive(1'b1, 16'h34, "R6 last elem");
    drive(1'b0, 16'h00, "R7 tail");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule